// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine with Selectable Bus Sharing

This block copies a run of bytes between one peripheral data port and memory so that the processor does not handle each byte itself. Software loads a start address and a byte count, then writes the control word. The control word sets the direction, the way the shared bus is shared, an interrupt enable, a device selector and a launch bit. The engine then moves one byte per permitted cycle. After each byte the address goes up by one and the count goes down by one. When the count reaches zero the engine sets a done flag and, if enabled, raises an interrupt.

Three sharing policies can be chosen at run time. In hold mode the engine keeps its bus request up for the whole block. In single-cycle mode it gives the bus back after every byte and asks again. In idle-only mode it never requests the bus and moves a byte only in cycles when the processor reports the bus as unused. Each byte is a single-cycle access: the memory strobe is driven in the same cycle as the grant (or the idle indication), and read data from memory is passed straight to the device.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset, busy, done, the interrupt, the bus request and the memory strobe are all low, and the address and count registers read back as zero.
- R2: Register select 0 is the address, 1 is the count, 2 is control and 3 is status. Control bits: bit0 launches the transfer (write-only, reads 0); bit1 sets direction (1 = memory to device, 0 = device to memory); bits3:2 set the mode (0 hold, 1 single-cycle, 2 idle-only, 3 behaves as hold); bit4 enables the interrupt; bits7:5 hold the device selector, which drives the device-select output. Status bits: bit0 busy, bit1 done.
- R3: Each moved byte increments the address by one and decrements the count by one. A block of N bytes ends with the count at 0 and the address at start+N. Device-to-memory writes the device byte to memory; memory-to-device forwards the memory byte to the device port.
- R4: The memory strobe is asserted in hold and single-cycle modes only in cycles where the bus grant is high. With the request up and no grant, no byte moves.
- R5: In hold mode the bus request stays high in every busy cycle from launch to the last byte, and one byte moves in each granted cycle.
- R6: In single-cycle mode the request is low in the cycle after each moved byte, and it is raised again in the following cycle while bytes remain.
- R7: In idle-only mode the bus request is never asserted, and bytes move only in cycles where the processor-idle input is high.
- R8: The clock edge that moves the last byte clears busy and sets done. The interrupt output equals done AND the interrupt enable.
- R9: Writing status with bit1 set clears done, and with it the interrupt.
- R10: Writes to address, count or control, including the launch bit, have no effect while busy.
- R11: Launching with a count of zero sets done on the launch edge, without busy, bus request or memory strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the selected register |
| bus_req | output | 1 | Shared-bus request |
| bus_gnt | input | 1 | Shared-bus grant |
| cpu_bus_idle | input | 1 | Processor leaves the bus unused this cycle |
| mem_addr | output | 16 | Memory byte address |
| mem_stb | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte read from memory, same cycle |
| dev_sel | output | 3 | Device selector from control |
| dev_stb | output | 1 | Device byte accepted or supplied this cycle |
| dev_rdata | input | 8 | Byte offered by the device |
| dev_wdata | output | 8 | Byte delivered to the device |
| irq | output | 1 | Completion interrupt |

## Verification
Assertions check every cycle that a strobe in a bus-owning mode coincides with a grant, that single-cycle mode drops its request after each byte, and that hold mode keeps its request up. They also check that idle-only mode moves bytes only on idle cycles, that the address and count step together and stay frozen when no byte moves, and that busy and done are never high together. The data contents copied in each direction, the exact byte counts, register readback after ignored writes, the zero-count launch and interrupt clearing are shown only by the bench's directed scenarios, which compare memory and device logs against values computed from the requirements.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int CB_START   = 0;
  localparam int CB_DIR     = 1;
  localparam int CB_MODE_LO = 2;
  localparam int CB_IE      = 4;
  localparam int CB_DEV_LO  = 5;

  localparam int SB_BUSY = 0;
  localparam int SB_DONE = 1;

  typedef enum logic [1:0] {
    BUS_HOLD    = 2'd0,
    BUS_ONESHOT = 2'd1,
    BUS_SNOOP   = 2'd2
  } bus_policy_e;

  function automatic bus_policy_e policy_of(input logic [1:0] code);
    case (code)
      2'd1:    return BUS_ONESHOT;
      2'd2:    return BUS_SNOOP;
      default: return BUS_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
  import dma_xfer_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEV_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_sel,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                busy,
  input  logic                done,
  input  logic [ADDR_W-1:0]   walk_addr,
  input  logic [CNT_W-1:0]    walk_cnt,
  output logic                launch,
  output logic                clr_done,
  output logic                addr_wr_en,
  output logic                cnt_wr_en,
  output logic [ADDR_W-1:0]   addr_wr_val,
  output logic [CNT_W-1:0]    cnt_wr_val,
  output logic                dir_m2d,
  output bus_policy_e         policy,
  output logic                irq_en,
  output logic [DEV_W-1:0]    dev_id
);

  logic             ctrl_wr;
  logic             dir_q, dir_d;
  logic [1:0]       mode_q, mode_d;
  logic             ie_q, ie_d;
  logic [DEV_W-1:0] dev_q, dev_d;

  assign ctrl_wr     = reg_wr && (reg_sel == SEL_CTRL) && !busy;
  assign addr_wr_en  = reg_wr && (reg_sel == SEL_ADDR) && !busy;
  assign cnt_wr_en   = reg_wr && (reg_sel == SEL_CNT)  && !busy;
  assign clr_done    = reg_wr && (reg_sel == SEL_STAT) && reg_wdata[SB_DONE];
  assign launch      = ctrl_wr && reg_wdata[CB_START];
  assign addr_wr_val = reg_wdata[ADDR_W-1:0];
  assign cnt_wr_val  = reg_wdata[CNT_W-1:0];

  always_comb begin
    dir_d  = dir_q;
    mode_d = mode_q;
    ie_d   = ie_q;
    dev_d  = dev_q;
    if (ctrl_wr) begin
      dir_d  = reg_wdata[CB_DIR];
      mode_d = reg_wdata[CB_MODE_LO +: 2];
      ie_d   = reg_wdata[CB_IE];
      dev_d  = reg_wdata[CB_DEV_LO +: DEV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      mode_q <= 2'd0;
      ie_q   <= 1'b0;
      dev_q  <= '0;
    end else if (ctrl_wr) begin
      dir_q  <= dir_d;
      mode_q <= mode_d;
      ie_q   <= ie_d;
      dev_q  <= dev_d;
    end
  end

  assign dir_m2d = dir_q;
  assign policy  = policy_of(mode_q);
  assign irq_en  = ie_q;
  assign dev_id  = dev_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_ADDR: reg_rdata = REG_W'(walk_addr);
      SEL_CNT:  reg_rdata = REG_W'(walk_cnt);
      SEL_CTRL: begin
        reg_rdata[CB_DIR]              = dir_q;
        reg_rdata[CB_MODE_LO +: 2]     = mode_q;
        reg_rdata[CB_IE]               = ie_q;
        reg_rdata[CB_DEV_LO +: DEV_W]  = dev_q;
      end
      default: begin
        reg_rdata[SB_BUSY] = busy;
        reg_rdata[SB_DONE] = done;
      end
    endcase
  end

  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q) && $stable(dir_q) && $stable(ie_q)) else $error("control changed while busy"); // R10

endmodule

// File: rtl/dma_xfer_arb.sv
module dma_xfer_arb
  import dma_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy,
  input  bus_policy_e policy,
  input  logic        bus_gnt,
  input  logic        cpu_bus_idle,
  output logic        bus_req,
  output logic        fire
);

  logic gap_q, gap_d;

  assign bus_req = busy && (policy != BUS_SNOOP) && !gap_q;
  assign fire    = busy && ((policy == BUS_SNOOP) ? cpu_bus_idle : (bus_req && bus_gnt));

  always_comb begin
    gap_d = (policy == BUS_ONESHOT) && fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= 1'b0;
    else        gap_q <= gap_d;
  end

  AST_ONESHOT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && policy == BUS_ONESHOT) |=> !bus_req) else $error("single-cycle mode kept the bus"); // R6

  AST_ONESHOT_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && policy == BUS_ONESHOT && !bus_req) |=> (bus_req || !busy)) else $error("single-cycle mode did not re-request"); // R6

  AST_HOLD_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && policy == BUS_HOLD && $past(busy)) |-> bus_req) else $error("hold mode dropped request"); // R5

endmodule

// File: rtl/dma_xfer_walker.sv
module dma_xfer_walker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              fire,
  input  logic              clr_done,
  input  logic              addr_wr_en,
  input  logic              cnt_wr_en,
  input  logic [ADDR_W-1:0] addr_wr_val,
  input  logic [CNT_W-1:0]  cnt_wr_val,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              busy,
  output logic              done
);

  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              busy_d, done_d;
  logic              upd_en;

  always_comb begin
    addr_d = addr;
    cnt_d  = cnt;
    busy_d = busy;
    done_d = done;
    if (busy) begin
      if (fire) begin
        addr_d = addr + ADDR_ONE;
        cnt_d  = cnt - CNT_ONE;
        if (cnt == CNT_ONE) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end else begin
      if (addr_wr_en) addr_d = addr_wr_val;
      if (cnt_wr_en)  cnt_d  = cnt_wr_val;
      if (clr_done)   done_d = 1'b0;
      if (launch) begin
        if (cnt == '0) begin
          done_d = 1'b1;
        end else begin
          busy_d = 1'b1;
          done_d = 1'b0;
        end
      end
    end
  end

  assign upd_en = (busy && fire) || (!busy && (addr_wr_en || cnt_wr_en || clr_done || launch));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (upd_en) begin
      addr <= addr_d;
      cnt  <= cnt_d;
      busy <= busy_d;
      done <= done_d;
    end
  end

  AST_STEP_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fire) |=> (addr == $past(addr) + ADDR_ONE) && (cnt == $past(cnt) - CNT_ONE)) else $error("address/count step mismatch"); // R3

  AST_FROZEN_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire) |=> $stable(addr) && $stable(cnt)) else $error("address/count moved without a byte"); // R10

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)) else $error("busy and done together"); // R8

  AST_ZERO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy && cnt == '0 && !cnt_wr_en) |=> (done && !busy)) else $error("zero-count launch did not finish"); // R11

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int DEV_W  = 3,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              cpu_bus_idle,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_stb,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DEV_W-1:0]  dev_sel,
  output logic              dev_stb,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              irq
);

  logic [1:0]        rst_sync_q;
  logic              rst_q;
  logic              launch, clr_done, addr_wr_en, cnt_wr_en;
  logic [ADDR_W-1:0] addr_wr_val, walk_addr;
  logic [CNT_W-1:0]  cnt_wr_val, walk_cnt;
  logic              busy, done, fire, dir_m2d, irq_en;
  bus_policy_e       policy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  dma_xfer_regs #(
    .REG_W (REG_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .DEV_W (DEV_W)
  ) regs_i (
    .clk        (clk),
    .rst_n      (rst_q),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .done       (done),
    .walk_addr  (walk_addr),
    .walk_cnt   (walk_cnt),
    .launch     (launch),
    .clr_done   (clr_done),
    .addr_wr_en (addr_wr_en),
    .cnt_wr_en  (cnt_wr_en),
    .addr_wr_val(addr_wr_val),
    .cnt_wr_val (cnt_wr_val),
    .dir_m2d    (dir_m2d),
    .policy     (policy),
    .irq_en     (irq_en),
    .dev_id     (dev_sel)
  );

  dma_xfer_arb arb_i (
    .clk         (clk),
    .rst_n       (rst_q),
    .busy        (busy),
    .policy      (policy),
    .bus_gnt     (bus_gnt),
    .cpu_bus_idle(cpu_bus_idle),
    .bus_req     (bus_req),
    .fire        (fire)
  );

  dma_xfer_walker #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) walker_i (
    .clk        (clk),
    .rst_n      (rst_q),
    .launch     (launch),
    .fire       (fire),
    .clr_done   (clr_done),
    .addr_wr_en (addr_wr_en),
    .cnt_wr_en  (cnt_wr_en),
    .addr_wr_val(addr_wr_val),
    .cnt_wr_val (cnt_wr_val),
    .addr       (walk_addr),
    .cnt        (walk_cnt),
    .busy       (busy),
    .done       (done)
  );

  assign mem_addr  = walk_addr;
  assign mem_stb   = fire;
  assign mem_we    = fire && !dir_m2d;
  assign mem_wdata = dev_rdata;
  assign dev_stb   = fire;
  assign dev_wdata = mem_rdata;
  assign irq       = done && irq_en;

  AST_STB_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_stb && policy != BUS_SNOOP) |-> bus_gnt) else $error("strobe without grant"); // R4

  AST_SNOOP_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_stb && policy == BUS_SNOOP) |-> (cpu_bus_idle && !bus_req)) else $error("idle-only mode used a busy bus"); // R7

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_q)
    bus_req |-> busy) else $error("request while idle"); // R4

endmodule

// File: tb/dma_xfer_ctrl_tb_top.sv
module dma_xfer_ctrl_tb_top;

  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [15:0] reg_wdata, reg_rdata;
  logic        bus_req, bus_gnt, cpu_bus_idle, gnt_allow;
  logic [15:0] mem_addr;
  logic        mem_stb, mem_we;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [2:0]  dev_sel;
  logic        dev_stb;
  logic [7:0]  dev_rdata, dev_wdata;
  logic        irq;

  logic [7:0]  mem [0:255];
  logic [7:0]  dev_src;
  logic [7:0]  dev_log [0:63];
  int          dev_n;
  int          total = 0;
  int          bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_xfer_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .cpu_bus_idle(cpu_bus_idle), .mem_addr(mem_addr),
    .mem_stb(mem_stb), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dev_sel(dev_sel), .dev_stb(dev_stb),
    .dev_rdata(dev_rdata), .dev_wdata(dev_wdata), .irq(irq)
  );

  assign bus_gnt   = gnt_allow & bus_req;
  assign mem_rdata = mem[mem_addr[7:0]];
  assign dev_rdata = dev_src;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h3C;
      dev_src <= 8'h11;
      dev_n   <= 0;
    end else begin
      if (mem_stb && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (dev_stb) begin
        dev_src <= dev_src + 8'd7;
        if (dev_n < 64) dev_log[dev_n] <= dev_wdata;
        dev_n <= dev_n + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic reg_read(input logic [1:0] s, output int v);
    reg_sel = s;
    #1;
    v = int'(reg_rdata);
    reg_sel = 2'd3;
    #1;
  endtask

  task automatic t_reset();
    int v;
    chk("R1 bus_req", int'(bus_req), 0);
    chk("R1 mem_stb", int'(mem_stb), 0);
    chk("R1 irq", int'(irq), 0);
    reg_read(2'd3, v); chk("R1 status", v, 0);
    reg_read(2'd0, v); chk("R1 address", v, 0);
    reg_read(2'd1, v); chk("R1 count", v, 0);
  endtask

  task automatic t_hold();
    int v, stb_n, drop;
    logic [7:0] s0;
    gnt_allow = 1'b1;
    s0 = dev_src;
    reg_write(2'd0, 16'h0010);
    reg_write(2'd1, 16'd5);
    reg_write(2'd2, 16'h0071);
    stb_n = 0; drop = 0;
    for (int k = 0; k < 30; k++) begin
      #1;
      if (reg_rdata[0]) begin
        if (!bus_req) drop++;
        if (mem_stb) stb_n++;
      end else break;
      @(negedge clk);
    end
    chk("R5 request held", drop, 0);
    chk("R5 bytes moved", stb_n, 5);
    chk("R2 dev_sel", int'(dev_sel), 3);
    for (int k = 0; k < 5; k++) chk("R3 dev->mem data", int'(mem[8'h10 + k]), int'(8'(s0 + 8'(7 * k))));
    reg_read(2'd3, v); chk("R8 status done", v, 2);
    chk("R8 irq enabled", int'(irq), 1);
    reg_read(2'd0, v); chk("R3 end address", v, 16'h0015);
    reg_read(2'd1, v); chk("R3 end count", v, 0);
    reg_read(2'd2, v); chk("R2 control readback", v, 16'h0070);
    reg_write(2'd3, 16'h0002);
    reg_read(2'd3, v); chk("R9 done cleared", v, 0);
    chk("R9 irq cleared", int'(irq), 0);
  endtask

  task automatic t_oneshot();
    int v, stb_n, keep, idle_gap, n0;
    logic prev;
    gnt_allow = 1'b1;
    n0 = dev_n;
    reg_write(2'd0, 16'h0010);
    reg_write(2'd1, 16'd4);
    reg_write(2'd2, 16'h0007);
    stb_n = 0; keep = 0; idle_gap = 0; prev = 1'b0;
    for (int k = 0; k < 40; k++) begin
      #1;
      if (!reg_rdata[0]) break;
      if (prev && bus_req) keep++;
      if (!prev && !bus_req) idle_gap++;
      if (mem_stb) stb_n++;
      prev = mem_stb;
      @(negedge clk);
    end
    chk("R6 released after byte", keep, 0);
    chk("R6 re-requested", idle_gap, 0);
    chk("R6 bytes moved", stb_n, 4);
    for (int k = 0; k < 4; k++) chk("R3 mem->dev data", int'(dev_log[n0 + k]), int'(mem[8'h10 + k]));
    reg_read(2'd3, v); chk("R8 done set", v, 2);
    chk("R8 irq masked", int'(irq), 0);
    reg_write(2'd3, 16'h0002);
  endtask

  task automatic t_snoop();
    int v, stb_n, req_seen, off_idle;
    logic [7:0] s0;
    gnt_allow = 1'b1;
    cpu_bus_idle = 1'b0;
    s0 = dev_src;
    reg_write(2'd0, 16'h0040);
    reg_write(2'd1, 16'd3);
    reg_write(2'd2, 16'h0009);
    stb_n = 0; req_seen = 0; off_idle = 0;
    for (int k = 0; k < 40; k++) begin
      cpu_bus_idle = (k % 3 == 2);
      #1;
      if (!reg_rdata[0]) break;
      if (bus_req) req_seen++;
      if (mem_stb) begin
        stb_n++;
        if (!cpu_bus_idle) off_idle++;
      end
      @(negedge clk);
    end
    cpu_bus_idle = 1'b0;
    chk("R7 no request", req_seen, 0);
    chk("R7 only on idle", off_idle, 0);
    chk("R7 bytes moved", stb_n, 3);
    for (int k = 0; k < 3; k++) chk("R7 data", int'(mem[8'h40 + k]), int'(8'(s0 + 8'(7 * k))));
    reg_read(2'd0, v); chk("R3 idle-only end address", v, 16'h0043);
    reg_write(2'd3, 16'h0002);
  endtask

  task automatic t_zero();
    int v;
    reg_write(2'd1, 16'd0);
    reg_write(2'd2, 16'h0011);
    chk("R11 no request", int'(bus_req), 0);
    chk("R11 no strobe", int'(mem_stb), 0);
    reg_read(2'd3, v); chk("R11 done without busy", v, 2);
    chk("R11 irq", int'(irq), 1);
    reg_write(2'd3, 16'h0002);
    chk("R9 irq cleared after zero launch", int'(irq), 0);
  endtask

  task automatic t_frozen();
    int v, stb_blk;
    gnt_allow = 1'b0;
    reg_write(2'd0, 16'h0080);
    reg_write(2'd1, 16'd3);
    reg_write(2'd2, 16'h00B1);
    reg_write(2'd0, 16'h0099);
    reg_write(2'd1, 16'd9);
    reg_write(2'd2, 16'h000F);
    stb_blk = 0;
    for (int k = 0; k < 4; k++) begin
      #1;
      if (mem_stb) stb_blk++;
      @(negedge clk);
    end
    chk("R4 no strobe without grant", stb_blk, 0);
    chk("R4 request pending", int'(bus_req), 1);
    reg_read(2'd0, v); chk("R10 address kept", v, 16'h0080);
    reg_read(2'd1, v); chk("R10 count kept", v, 3);
    reg_read(2'd2, v); chk("R10 control kept", v, 16'h00B0);
    gnt_allow = 1'b1;
    for (int k = 0; k < 20; k++) begin
      #1;
      if (!reg_rdata[0]) break;
      @(negedge clk);
    end
    reg_read(2'd0, v); chk("R10 finished at programmed end", v, 16'h0083);
    chk("R10 ignored target untouched", int'(mem[8'h99]), int'(8'h99 ^ 8'h3C));
    reg_write(2'd3, 16'h0002);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
    gnt_allow = 1'b0; cpu_bus_idle = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hold();
    t_oneshot();
    t_snoop();
    t_zero();
    t_frozen();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule